// File: doc/BRIEF.md
# Synthesizer Divider-Ratio Search Engine

This block searches for the integer ratios that let a frequency synthesizer produce a requested output clock. It is given a reference frequency and a target frequency, both in kHz. It returns three integers: an input divider D, a feedback multiplier M and an output divider O. The synthesized frequency is fin*M/D/O, and the block picks the ratios that bring it as close as possible to the target. Every candidate must keep the phase-comparison frequency fin/D and the oscillator frequency fin*M/D inside their legal windows.

A single start pulse launches a search. Each division in the search, whether it is a ceiling, a floor or a nearest-rounding division, goes through one shared sequential divider. The divider produces one quotient bit per clock. The search walks M in ascending order. For each M it walks the D values allowed at that M in ascending order. It keeps the first candidate with the smallest error, and it stops as soon as it hits the target exactly. When the search ends, the block gives a single done pulse and holds the results.

Top module: `synth_param_search`

## Requirements
- R1: After reset, busy, done and fail are 0, and all three ratio outputs are 0.
- R2: A start with fin_khz of 0 or fout_khz of 0 runs no search. Done follows within 4 cycles of the start, with fail=1 and all three ratios 0.
- R3: A successful result satisfies 1 <= D <= 80 and 1 <= M <= 64. It satisfies 10000 <= floor(fin/D) <= 300000 and 600000 <= floor(fin*M/D) <= 1200000. It also satisfies 1 <= O <= 128.
- R4: The D limits are lo=max(ceil(fin/300000),1) and hi=min(floor(fin/10000),80). M runs from max(ceil(600000/fin)*lo,1) to min(floor(1200000*hi/fin),64). For each M, D runs from max(lo,ceil(fin*M/1200000)) to min(hi,floor(fin*M/600000)).
- R5: For each candidate, v=floor(fin*M/D). O is floor((v+floor(fout/2))/fout), limited to the range 1..128. The achieved frequency is floor(v/O).
- R6: A candidate replaces the stored one only if its absolute error is strictly smaller, so the earliest candidate wins a tie. The stored error starts at 2^32-1.
- R7: The search stops at the first candidate whose achieved frequency equals the target.
- R8: If no candidate is evaluated, D, M and O are reported as 0 and fail is 1. Otherwise fail is 0.
- R9: A start pulse while busy is ignored, and the running search finishes with its own inputs.
- R10: busy is 1 from the cycle after an accepted start until the search ends. done is a one-cycle pulse in the first cycle with busy back at 0.
- R11: D, M, O and fail change only in the cycle where done is 1. They hold their values at all other times, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a search |
| fin_khz | input | 32 | Reference frequency in kHz, captured at start |
| fout_khz | input | 32 | Target frequency in kHz, captured at start |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| fail | output | 1 | No legal candidate was found, or an input was zero |
| res_in_div | output | 8 | Chosen input divider D |
| res_fb_mult | output | 8 | Chosen feedback multiplier M |
| res_out_div | output | 8 | Chosen output divider O |

## Verification
The block is driven with several kinds of reference and target pairs. Some pairs have a reachable exact target, where both the result and a short done latency show that the search stopped early. Other random pairs have no exact match, so the search runs through the whole M and D space and exercises the tie and strict-improvement rules against a bench model. A reference below the phase-comparison minimum gives an empty search space, which separates the failure path from the zero-input rejection path. Further cases change the inputs and pulse start while a search is running, or while the results are held, to show that the running search and the held results are not disturbed.

// File: rtl/srch_pkg.sv
package srch_pkg;

    localparam int unsigned DW = 32;

    localparam logic [DW-1:0] PFD_LO  = 32'd10000;
    localparam logic [DW-1:0] PFD_HI  = 32'd300000;
    localparam logic [DW-1:0] VCO_LO  = 32'd600000;
    localparam logic [DW-1:0] VCO_HI  = 32'd1200000;
    localparam logic [DW-1:0] D_CAP   = 32'd80;
    localparam logic [DW-1:0] M_CAP   = 32'd64;
    localparam logic [DW-1:0] O_CAP   = 32'd128;
    localparam logic [DW-1:0] ERR_INIT = '1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DLO,
        ST_DHI,
        ST_MLO,
        ST_MHI,
        ST_MCHK,
        ST_RLO,
        ST_RHI,
        ST_DCHK,
        ST_VCO,
        ST_ODIV,
        ST_ACH,
        ST_EVAL,
        ST_FIN
    } srch_state_e;

    typedef struct packed {
        logic [DW-1:0] d;
        logic [DW-1:0] m;
        logic [DW-1:0] o;
    } ratio_t;

    function automatic logic [DW-1:0] umax(input logic [DW-1:0] a, input logic [DW-1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [DW-1:0] umin(input logic [DW-1:0] a, input logic [DW-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [DW-1:0] udiff(input logic [DW-1:0] a, input logic [DW-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    function automatic logic [DW-1:0] odiv_limit(input logic [DW-1:0] q);
        if (q == '0)
            return 32'd1;
        else if (q > O_CAP)
            return O_CAP;
        else
            return q;
    endfunction

endpackage

// File: rtl/srch_div_seq.sv
module srch_div_seq #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic          done_q;
    logic [W:0]    shifted;
    logic [W:0]    diff;
    logic          fits;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        diff    = shifted - {1'b0, den_q};
        fits    = (shifted >= {1'b0, den_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !run_q) begin
                rem_q <= '0;
                quo_q <= num;
                den_q <= den;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign quo  = quo_q;

endmodule

// File: rtl/srch_best_keep.sv
module srch_best_keep
    import srch_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          cand_valid,
    input  ratio_t        cand,
    input  logic [DW-1:0] cand_err,
    output ratio_t        best
);
    ratio_t        best_q;
    logic [DW-1:0] err_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            best_q <= '0;
            err_q  <= ERR_INIT;
        end else if (cand_valid && (cand_err < err_q)) begin
            best_q <= cand;
            err_q  <= cand_err;
        end
    end

    assign best = best_q;

endmodule

// File: rtl/synth_param_search.sv
module synth_param_search
    import srch_pkg::*;
#(
    parameter int unsigned RES_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DW-1:0]    fin_khz,
    input  logic [DW-1:0]    fout_khz,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic [RES_W-1:0] res_in_div,
    output logic [RES_W-1:0] res_fb_mult,
    output logic [RES_W-1:0] res_out_div
);
    srch_state_e   st_q;
    logic [DW-1:0] fin_q, fout_q;
    logic [DW-1:0] dlo_q, dhi_q, mlo_q, mhi_q;
    logic [DW-1:0] m_q, d_q, rhi_q;
    logic [DW-1:0] vco_q, odiv_q, ach_q;
    logic          wait_q;
    logic          done_q, fail_q;
    logic [RES_W-1:0] rd_q, rm_q, ro_q;

    logic          div_state;
    logic          div_go;
    logic          div_done;
    logic [DW-1:0] div_num, div_den, div_quo;
    logic [DW-1:0] fin_m;
    logic          trk_clear, trk_valid;
    ratio_t        cand, best;
    logic [DW-1:0] cand_err;

    assign fin_m = fin_q * m_q;

    always_comb begin
        div_num = fin_q;
        div_den = PFD_LO;
        div_state = 1'b1;
        case (st_q)
            ST_DLO:  begin div_num = fin_q + PFD_HI - 32'd1; div_den = PFD_HI; end
            ST_DHI:  begin div_num = fin_q;                  div_den = PFD_LO; end
            ST_MLO:  begin div_num = VCO_LO + fin_q - 32'd1; div_den = fin_q;  end
            ST_MHI:  begin div_num = VCO_HI * dhi_q;         div_den = fin_q;  end
            ST_RLO:  begin div_num = fin_m + VCO_HI - 32'd1; div_den = VCO_HI; end
            ST_RHI:  begin div_num = fin_m;                  div_den = VCO_LO; end
            ST_VCO:  begin div_num = fin_m;                  div_den = d_q;    end
            ST_ODIV: begin div_num = vco_q + (fout_q >> 1);  div_den = fout_q; end
            ST_ACH:  begin div_num = vco_q;                  div_den = odiv_q; end
            default: div_state = 1'b0;
        endcase
    end

    assign div_go = div_state && !wait_q;

    srch_div_seq #(.W(DW)) div_i (
        .clk   (clk),
        .rst   (rst),
        .start (div_go),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    assign trk_clear  = (st_q == ST_IDLE) && start;
    assign trk_valid  = (st_q == ST_EVAL);
    assign cand.d     = d_q;
    assign cand.m     = m_q;
    assign cand.o     = odiv_q;
    assign cand_err   = udiff(ach_q, fout_q);

    srch_best_keep keep_i (
        .clk        (clk),
        .rst        (rst),
        .clear      (trk_clear),
        .cand_valid (trk_valid),
        .cand       (cand),
        .cand_err   (cand_err),
        .best       (best)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            fin_q  <= '0;
            fout_q <= '0;
            dlo_q  <= '0;
            dhi_q  <= '0;
            mlo_q  <= '0;
            mhi_q  <= '0;
            m_q    <= '0;
            d_q    <= '0;
            rhi_q  <= '0;
            vco_q  <= '0;
            odiv_q <= '0;
            ach_q  <= '0;
            wait_q <= 1'b0;
            done_q <= 1'b0;
            fail_q <= 1'b0;
            rd_q   <= '0;
            rm_q   <= '0;
            ro_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (div_go)
                wait_q <= 1'b1;
            if (div_done)
                wait_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        fin_q  <= fin_khz;
                        fout_q <= fout_khz;
                        if (fin_khz == '0 || fout_khz == '0)
                            st_q <= ST_FIN;
                        else
                            st_q <= ST_DLO;
                    end
                end
                ST_DLO: if (div_done) begin
                    dlo_q <= umax(div_quo, 32'd1);
                    st_q  <= ST_DHI;
                end
                ST_DHI: if (div_done) begin
                    dhi_q <= umin(div_quo, D_CAP);
                    st_q  <= ST_MLO;
                end
                ST_MLO: if (div_done) begin
                    mlo_q <= umax(div_quo * dlo_q, 32'd1);
                    st_q  <= ST_MHI;
                end
                ST_MHI: if (div_done) begin
                    mhi_q <= umin(div_quo, M_CAP);
                    m_q   <= mlo_q;
                    st_q  <= ST_MCHK;
                end
                ST_MCHK: st_q <= (m_q > mhi_q) ? ST_FIN : ST_RLO;
                ST_RLO: if (div_done) begin
                    d_q  <= umax(dlo_q, div_quo);
                    st_q <= ST_RHI;
                end
                ST_RHI: if (div_done) begin
                    rhi_q <= umin(dhi_q, div_quo);
                    st_q  <= ST_DCHK;
                end
                ST_DCHK: begin
                    if (d_q > rhi_q) begin
                        m_q  <= m_q + 32'd1;
                        st_q <= ST_MCHK;
                    end else begin
                        st_q <= ST_VCO;
                    end
                end
                ST_VCO: if (div_done) begin
                    vco_q <= div_quo;
                    st_q  <= ST_ODIV;
                end
                ST_ODIV: if (div_done) begin
                    odiv_q <= odiv_limit(div_quo);
                    st_q   <= ST_ACH;
                end
                ST_ACH: if (div_done) begin
                    ach_q <= div_quo;
                    st_q  <= ST_EVAL;
                end
                ST_EVAL: begin
                    if (ach_q == fout_q) begin
                        st_q <= ST_FIN;
                    end else begin
                        d_q  <= d_q + 32'd1;
                        st_q <= ST_DCHK;
                    end
                end
                ST_FIN: begin
                    done_q <= 1'b1;
                    fail_q <= (best.m == '0);
                    rd_q   <= best.d[RES_W-1:0];
                    rm_q   <= best.m[RES_W-1:0];
                    ro_q   <= best.o[RES_W-1:0];
                    st_q   <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (st_q != ST_IDLE);
    assign done        = done_q;
    assign fail        = fail_q;
    assign res_in_div  = rd_q;
    assign res_fb_mult = rm_q;
    assign res_out_div = ro_q;

endmodule

// File: rtl/srch_param_chk.sv
module srch_param_chk #(
    parameter int unsigned RES_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             fail,
    input logic [RES_W-1:0] res_in_div,
    input logic [RES_W-1:0] res_fb_mult,
    input logic [RES_W-1:0] res_out_div
);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    assert_busy_exit_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(res_in_div) && $stable(res_fb_mult)
                   && $stable(res_out_div) && $stable(fail)));

    assert_fail_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (done && fail) |-> (res_in_div == '0 && res_fb_mult == '0 && res_out_div == '0));

    assert_range_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !fail) |-> (res_in_div >= RES_W'(1) && res_in_div <= RES_W'(80)
                             && res_fb_mult >= RES_W'(1) && res_fb_mult <= RES_W'(64)
                             && res_out_div >= RES_W'(1) && res_out_div <= RES_W'(128)));
endmodule

bind synth_param_search srch_param_chk #(.RES_W(RES_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .done        (done),
    .fail        (fail),
    .res_in_div  (res_in_div),
    .res_fb_mult (res_fb_mult),
    .res_out_div (res_out_div)
);

// File: tb/synth_param_search_tb.sv
module synth_param_search_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] fin_khz = '0;
    logic [31:0] fout_khz = '0;
    logic        busy, done, fail;
    logic [7:0]  res_in_div, res_fb_mult, res_out_div;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    synth_param_search dut_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .fin_khz     (fin_khz),
        .fout_khz    (fout_khz),
        .busy        (busy),
        .done        (done),
        .fail        (fail),
        .res_in_div  (res_in_div),
        .res_fb_mult (res_fb_mult),
        .res_out_div (res_out_div)
    );

    task automatic chk(input string tag, input bit ok, input string detail);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s", tag, detail);
        end
    endtask

    function automatic void model(input longint fin, input longint fout,
                                  output longint bd, output longint bm, output longint bo);
        longint lo, hi, mlo, mhi, rlo, rhi, v, o, f, e, best_e;
        bd = 0; bm = 0; bo = 0;
        if (fin == 0 || fout == 0) return;
        lo  = (fin + 299999) / 300000; if (lo < 1) lo = 1;
        hi  = fin / 10000;             if (hi > 80) hi = 80;
        mlo = ((600000 + fin - 1) / fin) * lo; if (mlo < 1) mlo = 1;
        mhi = (1200000 * hi) / fin;    if (mhi > 64) mhi = 64;
        best_e = 64'd4294967295;
        for (longint m = mlo; m <= mhi; m++) begin
            rlo = (fin * m + 1199999) / 1200000; if (rlo < lo) rlo = lo;
            rhi = (fin * m) / 600000;            if (rhi > hi) rhi = hi;
            for (longint d = rlo; d <= rhi; d++) begin
                v = (fin * m) / d;
                o = (v + fout / 2) / fout;
                if (o < 1) o = 1;
                if (o > 128) o = 128;
                f = v / o;
                e = (f > fout) ? f - fout : fout - f;
                if (e < best_e) begin
                    best_e = e; bd = d; bm = m; bo = o;
                    if (f == fout) return;
                end
            end
        end
    endfunction

    task automatic pulse_start(input logic [31:0] fi, input logic [31:0] fo);
        @(negedge clk);
        fin_khz = fi; fout_khz = fo; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 1;
        while (!done && cyc < 40000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) chk("R10", 1'b0, "done never seen: actual=0 expected=1");
    endtask

    task automatic check_result(input string tag, input longint fi, input longint fo);
        longint ed, em, eo;
        bit ef;
        model(fi, fo, ed, em, eo);
        ef = (em == 0);
        chk(tag, res_in_div == ed && res_fb_mult == em && res_out_div == eo && fail == ef,
            $sformatf("fin=%0d fout=%0d actual D/M/O/fail=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d",
                      fi, fo, res_in_div, res_fb_mult, res_out_div, fail, ed, em, eo, ef));
        if (!ef) begin
            longint pfd, vco;
            pfd = fi / res_in_div;
            vco = (fi * res_fb_mult) / res_in_div;
            chk("R3", pfd >= 10000 && pfd <= 300000 && vco >= 600000 && vco <= 1200000,
                $sformatf("actual pfd=%0d vco=%0d expected pfd in 10000..300000 vco in 600000..1200000", pfd, vco));
        end
    endtask

    task automatic run_case(input string tag, input logic [31:0] fi, input logic [31:0] fo, output int cyc);
        pulse_start(fi, fo);
        chk("R10", busy == 1'b1, $sformatf("busy after start actual=%0b expected=1", busy));
        wait_done(cyc);
        chk("R10", busy == 1'b0, $sformatf("busy at done actual=%0b expected=0", busy));
        check_result(tag, fi, fo);
        @(negedge clk);
        chk("R10", done == 1'b0, $sformatf("done width actual=%0b expected=0", done));
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R10 watchdog: actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cyc;
        logic [7:0] hd, hm, ho;
        logic hf;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk("R1", !busy && !done && !fail && res_in_div == 0 && res_fb_mult == 0 && res_out_div == 0,
            $sformatf("reset state actual busy=%0b done=%0b fail=%0b D=%0d M=%0d O=%0d expected all 0",
                      busy, done, fail, res_in_div, res_fb_mult, res_out_div));
        rst = 1'b0;
        @(negedge clk);

        // R2: zero reference and zero target are rejected immediately
        pulse_start(32'd0, 32'd50000);
        wait_done(cyc);
        chk("R2", cyc <= 3 && fail && res_in_div == 0 && res_fb_mult == 0 && res_out_div == 0,
            $sformatf("zero fin actual cyc=%0d fail=%0b expected cyc<=3 fail=1", cyc, fail));
        pulse_start(32'd100000, 32'd0);
        wait_done(cyc);
        chk("R2", cyc <= 3 && fail,
            $sformatf("zero fout actual cyc=%0d fail=%0b expected cyc<=3 fail=1", cyc, fail));

        // R7: exact target reachable at the first candidate, early stop
        run_case("R7", 32'd100000, 32'd100000, cyc);
        chk("R7", cyc < 400, $sformatf("exact-hit latency actual=%0d expected<400", cyc));

        // R8: empty search space below the phase-comparison minimum
        run_case("R8", 32'd5000, 32'd25000, cyc);

        // R4 R5 R6: directed non-exact targets over the whole space
        run_case("R4", 32'd20000, 32'd33333, cyc);
        run_case("R5", 32'd100000, 32'd7, cyc);
        run_case("R5", 32'd27000, 32'd1500000, cyc);
        run_case("R6", 32'd50000, 32'd123457, cyc);

        // R9: start while busy is ignored
        pulse_start(32'd100000, 32'd33333);
        repeat (60) @(negedge clk);
        fin_khz = 32'd20000; fout_khz = 32'd77777; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc);
        check_result("R9", 100000, 33333);

        // R11: results hold while inputs move without start
        hd = res_in_div; hm = res_fb_mult; ho = res_out_div; hf = fail;
        fin_khz = 32'd5000; fout_khz = 32'd1;
        repeat (20) @(negedge clk);
        chk("R11", res_in_div == hd && res_fb_mult == hm && res_out_div == ho && fail == hf,
            $sformatf("held D/M/O actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                      res_in_div, res_fb_mult, res_out_div, hd, hm, ho));

        // R6: constrained random pairs against the bench model
        for (int i = 0; i < 4; i++) begin
            logic [31:0] fi, fo;
            fi = $urandom_range(120000, 10000);
            fo = $urandom_range(600000, 1000);
            run_case("R6", fi, fo, cyc);
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule